// File: doc/BRIEF.md
# Branch Condition Decider

This block settles whether a conditional branch is taken. A start strobe brings in the six low bits of a branch instruction word: a direction bit, an external-mode bit, a negate bit and a three-bit condition select. In the same cycle it brings in the current sign, zero, overflow and carry flags. In internal mode the block picks one of eight base conditions from the flags. The negate bit can complement the result. The decision comes out one cycle later as a single-cycle done strobe with a taken bit.

In external mode the flags are not used. The block drives the negate bit and the condition select, as a 4-bit code, on an address bus to outside logic. It samples a single external condition bit one clock later and reports that bit as the decision. While the block waits for that bit it shows busy and ignores new start strobes. The direction bit is passed through alongside the decision, for the offset adder that follows the block.

Top module: `branch_decider`

## Requirements
- R1: After reset, done_o, taken_o, dir_o, busy_o and ext_addr_o are all zero.
- R2: A start in internal mode (br_word_i[4]=0) while not busy raises done_o in the next cycle only, and done_o is low again the cycle after, unless another start arrives.
- R3: With br_word_i[3]=0, the select br_word_i[2:0] chooses a condition. The values are 0 always, 1 C, 2 O, 3 !S, 4 Z, 5 S^O, 6 Z|(S^O), 7 S^C. taken_o equals the chosen condition, evaluated on the flags present with the start.
- R4: With br_word_i[3]=1, taken_o is the complement of the R3 condition for the same select. Select 0 is therefore never taken.
- R5: A start in external mode (br_word_i[4]=1) drives ext_addr_o = br_word_i[3:0] in the next cycle. In that cycle busy_o=1 and done_o=0.
- R6: In the cycle after the one in which the external address is shown, done_o=1, taken_o equals the value ext_cond_i had in the address cycle, and ext_addr_o is back to zero.
- R7: The flags have no effect on an external-mode decision. ext_cond_i has no effect on an internal-mode decision. ext_addr_o stays zero whenever busy_o is low.
- R8: dir_o equals br_word_i[5] of the completed branch while done_o is high, and is zero otherwise.
- R9: taken_o is never high while done_o is low.
- R10: A start while busy_o is high is ignored. It produces no extra done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate the branch word this cycle |
| br_word_i | input | 6 | {dir, ext, neg, sel[2:0]} |
| flag_s_i | input | 1 | Sign flag |
| flag_z_i | input | 1 | Zero flag |
| flag_o_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| ext_cond_i | input | 1 | External branch condition |
| done_o | output | 1 | Decision valid strobe |
| taken_o | output | 1 | Branch taken, qualified by done_o |
| dir_o | output | 1 | Offset direction, qualified by done_o |
| busy_o | output | 1 | Waiting for the external condition |
| ext_addr_o | output | 4 | External condition code |

## Verification
The assertions check on every cycle that taken and direction stay low outside the done strobe, and that the address bus is quiet when the block is not busy. They also check that the external wait lasts exactly one cycle, closes with the sampled input bit and a cleared bus, and that an internal start completes in the next cycle. The truth of each of the sixteen condition codes over every flag combination can only be shown by the bench's sweeps. The same holds for the insensitivity to flags and external input, and for the dropping of starts that arrive while busy.

// File: rtl/brdec_pkg.sv
package brdec_pkg;
  localparam int COND_W = 3;
  localparam int COND_N = 1 << COND_W;
  localparam int CODE_W = COND_W + 1;
  localparam int WORD_W = CODE_W + 2;

  typedef enum logic [COND_W-1:0] {
    C_ALWAYS = 3'd0,
    C_CARRY  = 3'd1,
    C_OVFL   = 3'd2,
    C_PLUS   = 3'd3,
    C_EQ     = 3'd4,
    C_LT     = 3'd5,
    C_LE     = 3'd6,
    C_USC    = 3'd7
  } cond_e;

  typedef struct packed {
    logic              dir;
    logic              ext;
    logic              neg;
    logic [COND_W-1:0] sel;
  } br_word_t;

  typedef struct packed {
    logic s;
    logic z;
    logic o;
    logic c;
  } flags_t;
endpackage

// File: rtl/brdec_cond_mux.sv
module brdec_cond_mux
  import brdec_pkg::*;
(
  input  flags_t            flags_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  logic [COND_N-1:0]   base;
  logic [2*COND_N-1:0] tbl;

  always_comb begin
    base           = '0;
    base[C_ALWAYS] = 1'b1;
    base[C_CARRY]  = flags_i.c;
    base[C_OVFL]   = flags_i.o;
    base[C_PLUS]   = ~flags_i.s;
    base[C_EQ]     = flags_i.z;
    base[C_LT]     = flags_i.s ^ flags_i.o;
    base[C_LE]     = flags_i.z | (flags_i.s ^ flags_i.o);
    base[C_USC]    = flags_i.s ^ flags_i.c;
  end

  // upper half of the table holds the negated conditions
  for (genvar i = 0; i < COND_N; i++) begin : g_pol
    assign tbl[i]          = base[i];
    assign tbl[COND_N + i] = ~base[i];
  end

  assign hit_o = tbl[code_i];
endmodule

// File: rtl/brdec_seq.sv
module brdec_seq
  import brdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  br_word_t          word_i,
  input  logic              hit_i,
  input  logic              ext_cond_i,
  output logic              done_o,
  output logic              taken_o,
  output logic              dir_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] ext_addr_o
);
  typedef enum logic {S_IDLE, S_EXT} state_e;
  state_e state_q;
  logic   dir_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      done_o     <= 1'b0;
      taken_o    <= 1'b0;
      dir_o      <= 1'b0;
      dir_hold_q <= 1'b0;
      ext_addr_o <= '0;
    end else begin
      done_o  <= 1'b0;
      taken_o <= 1'b0;
      dir_o   <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (word_i.ext) begin
            ext_addr_o <= {word_i.neg, word_i.sel};
            dir_hold_q <= word_i.dir;
            state_q    <= S_EXT;
          end else begin
            done_o  <= 1'b1;
            taken_o <= hit_i;
            dir_o   <= word_i.dir;
          end
        end
        S_EXT: begin
          done_o     <= 1'b1;
          taken_o    <= ext_cond_i;
          dir_o      <= dir_hold_q;
          ext_addr_o <= '0;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == S_EXT);

  a_r9_taken_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> done_o);
  a_r8_dir_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !dir_o);
  a_r7_addr_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ext_addr_o == '0));
  a_r2_int_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !word_i.ext) |=> (done_o && !busy_o));
  a_r5_ext_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && word_i.ext) |=>
      (busy_o && !done_o && ext_addr_o == $past({word_i.neg, word_i.sel})));
  a_r6_ext_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (done_o && !busy_o && ext_addr_o == '0 && taken_o == $past(ext_cond_i)));
endmodule

// File: rtl/branch_decider.sv
module branch_decider
  import brdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] br_word_i,
  input  logic              flag_s_i,
  input  logic              flag_z_i,
  input  logic              flag_o_i,
  input  logic              flag_c_i,
  input  logic              ext_cond_i,
  output logic              done_o,
  output logic              taken_o,
  output logic              dir_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] ext_addr_o
);
  br_word_t word;
  flags_t   flags;
  logic     hit;

  assign word  = br_word_t'(br_word_i);
  assign flags = '{s: flag_s_i, z: flag_z_i, o: flag_o_i, c: flag_c_i};

  brdec_cond_mux u_mux (
    .flags_i (flags),
    .code_i  ({word.neg, word.sel}),
    .hit_o   (hit)
  );

  brdec_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .word_i     (word),
    .hit_i      (hit),
    .ext_cond_i (ext_cond_i),
    .done_o     (done_o),
    .taken_o    (taken_o),
    .dir_o      (dir_o),
    .busy_o     (busy_o),
    .ext_addr_o (ext_addr_o)
  );
endmodule

// File: tb/branch_decider_tb.sv
module branch_decider_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [5:0] br_word_i = '0;
  logic       flag_s_i = 1'b0, flag_z_i = 1'b0, flag_o_i = 1'b0, flag_c_i = 1'b0;
  logic       ext_cond_i = 1'b0;
  logic       done_o, taken_o, dir_o, busy_o;
  logic [3:0] ext_addr_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  branch_decider u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic cond_ref(input logic [2:0] sel, input logic neg, input logic [3:0] f);
    logic s, z, o, c, b;
    {s, z, o, c} = f;
    case (sel)
      3'd0: b = 1'b1;
      3'd1: b = c;
      3'd2: b = o;
      3'd3: b = !s;
      3'd4: b = z;
      3'd5: b = s != o;
      3'd6: b = z || (s != o);
      default: b = s != c;
    endcase
    return neg ? !b : b;
  endfunction

  task automatic set_flags(input logic [3:0] f);
    {flag_s_i, flag_z_i, flag_o_i, flag_c_i} = f;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {3'b0, done_o, taken_o, dir_o, busy_o, 1'b0}, 8'h0);
    chk("R1", {4'b0, ext_addr_o}, 8'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4 R7 R8 R9: sweep all internal words and all flags
    for (int w = 0; w < 16; w++) begin
      for (int f = 0; f < 16; f++) begin
        logic d, n; logic [2:0] sel; logic e;
        d = w[3]; n = w[2]; sel = 3'(w[1:0] + f[3:2] * 2) ^ 3'(w);
        sel = 3'(w);
        n = w[3];
        d = f[0] ^ w[0];
        start_i = 1'b1;
        br_word_i = {d, 1'b0, n, sel};
        set_flags(4'(f));
        ext_cond_i = ~cond_ref(sel, n, 4'(f));  // R7 must not matter
        @(negedge clk_i);
        start_i = 1'b0;
        set_flags(~4'(f));
        e = cond_ref(sel, n, 4'(f));
        chk(n ? "R4" : "R3", {7'b0, taken_o}, {7'b0, e});
        chk("R2", {7'b0, done_o}, 8'h1);
        chk("R8", {7'b0, dir_o}, {7'b0, d});
        chk("R7", {4'b0, ext_addr_o}, 8'h0);
        @(negedge clk_i);
        chk("R2", {7'b0, done_o}, 8'h0);
        chk("R9", {6'b0, taken_o, dir_o}, 8'h0);
      end
    end

    // R5 R6 R7 R8: external mode, all codes, both input values, varied flags
    for (int code = 0; code < 16; code++) begin
      for (int v = 0; v < 2; v++) begin
        logic d;
        d = code[0] ^ v[0];
        start_i = 1'b1;
        br_word_i = {d, 1'b1, 4'(code)};
        set_flags(4'(code * 5 + v));
        ext_cond_i = ~v[0];
        @(negedge clk_i);
        start_i = 1'b0;
        chk("R5", {4'b0, ext_addr_o}, 8'(code));
        chk("R5", {6'b0, busy_o, done_o}, 8'h2);
        ext_cond_i = v[0];
        set_flags(~4'(code));
        @(negedge clk_i);
        ext_cond_i = ~v[0];
        chk("R6", {7'b0, taken_o}, {7'b0, v[0]});
        chk("R6", {7'b0, done_o}, 8'h1);
        chk("R6", {4'b0, ext_addr_o}, 8'h0);
        chk("R8", {7'b0, dir_o}, {7'b0, d});
        @(negedge clk_i);
        chk("R9", {6'b0, done_o, taken_o}, 8'h0);
      end
    end

    // R10: start during the external wait is dropped
    start_i = 1'b1;
    br_word_i = 6'b011000;
    @(negedge clk_i);
    br_word_i = 6'b000000;     // internal always-taken, arrives while busy
    ext_cond_i = 1'b0;
    chk("R10", {7'b0, busy_o}, 8'h1);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10", {6'b0, done_o, taken_o}, 8'h2);
    @(negedge clk_i);
    chk("R10", {7'b0, done_o}, 8'h0);
    chk("R10", {7'b0, busy_o}, 8'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule